// File: doc/BRIEF.md
# Down-Counting Reload Timer Channel

This block is a single timer channel driven through a 32-bit word-addressed register port. A periodic enable pulse (`tick_en`) arrives at the peripheral rate. The channel divides it by a power-of-four ratio picked in the control word, and each divided step lowers a live counter by one. When a step finds the counter at zero, the counter takes the reload constant and a sticky underflow flag sets. The interrupt line is that flag masked by an enable bit. An external `start` level lets the count run or holds it.

Software programs the reload constant, the counter and the control word. It clears the flag by writing a zero to it. The control word also carries a capture mode and a capture flag, and their legality depends on two build-time features: an external-clock option and a capture option. Any access that sets a field the build does not allow, or that hits an offset that does not exist, is refused. `err` then pulses for one cycle.

Top module: `tmr_channel`

## Requirements
- R1: After reset, the reload word (byte 0x0) and the counter (byte 0x4) read 0xFFFFFFFF, the control word (byte 0x8) reads 0, and `irq` and `err` are low.
- R2: Bits [3:2] of `addr` select the word: 0 reload, 1 counter, 2 control, 3 capture. The reload and capture words read back what was written, and a reload write leaves the counter unchanged.
- R3: Control bits [2:0] select the division. Codes 0, 1, 2, 3 and 4 pass one count step per 4, 16, 64, 256 and 1024 `tick_en` pulses while `start` is high.
- R4: While `start` is low, `tick_en` pulses change neither the counter nor the position within the division period.
- R5: A count step taken while the counter is 0 loads the reload value and sets the underflow flag (control bit 8) on the same clock edge.
- R6: A legal control write with bit 8 at 0 clears the flag. A write with bit 8 at 1 leaves the flag as it was. No write ever sets the flag.
- R7: `irq` is high exactly when the flag and the interrupt enable (control bit 5) are both set.
- R8: A legal control write restarts the division period from zero, so the next step comes a full period after the write.
- R9: A control write is illegal if any of these holds: code 5; codes 6 or 7 without the external-clock option; nonzero bits [4:3] without that option; bits [7:6] equal to 1; bits [7:6] equal to 2 or 3 without the capture option; bit 9 set without the capture option; any of bits [31:10] set. An illegal write leaves control and flag unchanged and makes `err` high in the cycle after the write.
- R10: Control bit 9 (capture flag) always reads 0, even after a legal write of 1.
- R11: An access with `addr[1:0]` nonzero, or to word 3 without the capture option, changes no register, reads 0, and raises `err` in the next cycle.
- R12: A counter write loads the written value on the next edge, taking priority over a count step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Peripheral-rate enable pulse |
| start | input | 1 | Run (1) or hold (0) the count |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives error reporting) |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt: flag AND enable |
| err | output | 1 | One-cycle pulse after a refused access |

## Verification
The bench aims at the exact step count across all five dividers, including the 1024 case. A divider off by one step would show the counter one count away at the boundary pulse. It checks the zero-to-reload step. A design that decremented through zero, or set the flag one step late, would read 0xFFFFFFFF or a clear bit 8. Flag writes are exercised both ways, because a design that stored bit 8 from the bus would set the flag by a write. The illegal control codes are walked through a table, since accepting one would corrupt the stored control word. A second instance built without the capture option checks the refused offset and the refused capture fields.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int UF_BIT    = 8;
    localparam int CAPF_BIT  = 9;
    localparam int RSV_LSB   = 10;
    localparam int SHIFT_MAX = 10;
    localparam int SHIFT_W   = 4;

    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_CAPT   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] cap_mode;
        logic       uf_ie;
        logic [1:0] edge_sel;
        logic [2:0] psc;
    } ctrl_t;

    function automatic logic psc_internal(input logic [2:0] p);
        return p <= 3'd4;
    endfunction

    function automatic logic [SHIFT_W-1:0] psc_shift(input logic [2:0] p);
        return 4'd2 + {p, 1'b0};
    endfunction

    function automatic logic ctrl_legal(input logic [DATA_W-1:0] w,
                                        input logic has_ext,
                                        input logic has_capt);
        logic ok;
        ok = 1'b1;
        case (w[2:0])
            3'd5:       ok = 1'b0;
            3'd6, 3'd7: if (!has_ext) ok = 1'b0;
            default:    ;
        endcase
        if ((w[4:3] != 2'd0) && !has_ext) ok = 1'b0;
        if (w[7:6] == 2'd1) ok = 1'b0;
        if (w[7] && !has_capt) ok = 1'b0;
        if (w[CAPF_BIT] && !has_capt) ok = 1'b0;
        if (|w[DATA_W-1:RSV_LSB]) ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int MAX_SHIFT = SHIFT_MAX
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_en,
    input  logic               run,
    input  logic               clr,
    input  logic [SHIFT_W-1:0] shift,
    output logic               fire
);

    logic [MAX_SHIFT-1:0] pcnt;
    logic [MAX_SHIFT-1:0] term;

    always_comb begin
        for (int i = 0; i < MAX_SHIFT; i++) begin
            term[i] = (i < int'(shift));
        end
    end

    assign fire = run & tick_en & ~clr & (pcnt == term);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else if (clr) begin
            pcnt <= '0;
        end else if (run && tick_en) begin
            pcnt <= fire ? '0 : pcnt + 1'b1;
        end
    end

    a_r8_phase_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pcnt == '0));

    a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(pcnt));

    a_r3_wrap_after_fire: assert property (@(posedge clk) disable iff (rst)
        fire |=> (pcnt == '0));

endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt,
    output logic         uf
);

    assign uf = tick & ~load & (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '1;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt <= uf ? reload : cnt - 1'b1;
        end
    end

    a_r5_reload_on_zero: assert property (@(posedge clk) disable iff (rst)
        uf |=> (cnt == $past(reload)));

    a_r12_write_wins: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter bit HAS_EXT  = 1'b0,
    parameter bit HAS_CAPT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cnt_val,
    input  logic              uf,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] reload,
    output logic              cnt_load,
    output logic              ctrl_upd,
    output logic              irq,
    output logic              err,
    output logic [DATA_W-1:0] rdata
);

    localparam int CTRL_W = $bits(ctrl_t);

    reg_sel_e          sel;
    logic              bad_off;
    logic              wr_ok;
    logic              legal;
    logic              bad_ctrl;
    logic              flag_q;
    logic [DATA_W-1:0] capt_q;

    assign sel      = reg_sel_e'(addr[3:2]);
    assign bad_off  = (addr[1:0] != 2'b00) || (sel == SEL_CAPT && !HAS_CAPT);
    assign wr_ok    = wr_en & ~bad_off;
    assign legal    = ctrl_legal(wdata, HAS_EXT, HAS_CAPT);
    assign ctrl_upd = wr_ok & (sel == SEL_CTRL) & legal;
    assign bad_ctrl = wr_ok & (sel == SEL_CTRL) & ~legal;
    assign cnt_load = wr_ok & (sel == SEL_COUNT);
    assign irq      = flag_q & ctrl.uf_ie;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            reload <= '1;
            capt_q <= '0;
            flag_q <= 1'b0;
            err    <= 1'b0;
        end else begin
            if (wr_ok && sel == SEL_RELOAD) reload <= wdata;
            if (wr_ok && sel == SEL_CAPT)   capt_q <= wdata;
            if (ctrl_upd) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            flag_q <= uf | (flag_q & ~(ctrl_upd & ~wdata[UF_BIT]));
            err    <= ((wr_en || rd_en) && bad_off) || bad_ctrl;
        end
    end

    always_comb begin
        rdata = '0;
        if (!bad_off) begin
            case (sel)
                SEL_RELOAD: rdata = reload;
                SEL_COUNT:  rdata = cnt_val;
                SEL_CTRL:   begin
                    rdata[CTRL_W-1:0] = ctrl;
                    rdata[UF_BIT]     = flag_q;
                end
                SEL_CAPT:   rdata = capt_q;
                default:    rdata = '0;
            endcase
        end
    end

    a_r9_illegal_keeps_ctrl: assert property (@(posedge clk) disable iff (rst)
        bad_ctrl |=> ($stable(ctrl) && err));

    a_r6_write_never_sets: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !uf) |=> !$rose(flag_q));

    a_r6_zero_clears: assert property (@(posedge clk) disable iff (rst)
        (ctrl_upd && !wdata[UF_BIT]) |=> !flag_q);

    a_r11_bad_offset_err: assert property (@(posedge clk) disable iff (rst)
        ((wr_en || rd_en) && bad_off) |=> (err && $stable(reload)));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter bit HAS_EXT  = 1'b0,
    parameter bit HAS_CAPT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              start,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              err
);

    ctrl_t              ctrl;
    logic [DATA_W-1:0]  reload;
    logic [DATA_W-1:0]  cnt_val;
    logic               cnt_load;
    logic               ctrl_upd;
    logic               run;
    logic               step;
    logic               uf;
    logic [SHIFT_W-1:0] shift;

    assign run   = start & psc_internal(ctrl.psc);
    assign shift = psc_shift(ctrl.psc);

    tmr_regs #(
        .HAS_EXT (HAS_EXT),
        .HAS_CAPT(HAS_CAPT)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .cnt_val (cnt_val),
        .uf      (uf),
        .ctrl    (ctrl),
        .reload  (reload),
        .cnt_load(cnt_load),
        .ctrl_upd(ctrl_upd),
        .irq     (irq),
        .err     (err),
        .rdata   (rdata)
    );

    tmr_prescaler #(
        .MAX_SHIFT(SHIFT_MAX)
    ) u_psc (
        .clk    (clk),
        .rst    (rst),
        .tick_en(tick_en),
        .run    (run),
        .clr    (ctrl_upd),
        .shift  (shift),
        .fire   (step)
    );

    tmr_downcount #(
        .W(DATA_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (cnt_load),
        .load_val(wdata),
        .tick    (step),
        .reload  (reload),
        .cnt     (cnt_val),
        .uf      (uf)
    );

    a_r7_irq_follows_flag: assert property (@(posedge clk) disable iff (rst)
        uf |=> (irq == ctrl.uf_ie));

endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    // {write value to control, expected err, expected control readback}
    localparam logic [64:0] VEC [NVEC] = '{
        {32'h0000_0003, 1'b0, 32'h0000_0003},
        {32'h0000_0005, 1'b1, 32'h0000_0003},
        {32'h0000_0006, 1'b1, 32'h0000_0003},
        {32'h0000_0008, 1'b1, 32'h0000_0003},
        {32'h0000_0040, 1'b1, 32'h0000_0003},
        {32'h0000_00A4, 1'b0, 32'h0000_00A4},
        {32'h0000_0200, 1'b0, 32'h0000_0000},
        {32'h0000_0400, 1'b1, 32'h0000_0000},
        {32'h0000_00E1, 1'b0, 32'h0000_00E1},
        {32'h8000_0000, 1'b1, 32'h0000_00E1},
        {32'h0000_0100, 1'b0, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        start = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_nc;
    logic        irq, irq_nc, err, err_nc;
    logic [31:0] rv, rv_nc;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_channel u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .start(start),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .err(err)
    );

    tmr_channel #(.HAS_EXT(1'b0), .HAS_CAPT(1'b0)) u_dut_nc (
        .clk(clk), .rst(rst), .tick_en(tick_en), .start(start),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata_nc), .irq(irq_nc), .err(err_nc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        rv = rdata; rv_nc = rdata_nc;
        @(negedge clk);
        rd_en = 1'b0;
        #1;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 err", {31'b0, err}, 32'h0);
        rd(4'h0); chk("R1 reload", rv, 32'hFFFF_FFFF);
        rd(4'h4); chk("R1 counter", rv, 32'hFFFF_FFFF);
        rd(4'h8); chk("R1 control", rv, 32'h0);

        // R9 / R10 legality table
        for (int i = 0; i < NVEC; i++) begin
            wr(4'h8, VEC[i][64:33]);
            chk("R9 err", {31'b0, err}, {31'b0, VEC[i][32]});
            rd(4'h8);
            chk("R9/R10 control", rv, VEC[i][31:0]);
        end

        // R2 register selection
        wr(4'h0, 32'h1234_5678);
        rd(4'h0); chk("R2 reload", rv, 32'h1234_5678);
        rd(4'h4); chk("R2 counter untouched", rv, 32'hFFFF_FFFF);
        wr(4'hC, 32'hCAFE_0001);
        chk("R11 no-capture write err", {31'b0, err_nc}, 32'h1);
        chk("R2 capture write ok", {31'b0, err}, 32'h0);
        rd(4'hC);
        chk("R2 capture", rv, 32'hCAFE_0001);
        chk("R11 no-capture read", rv_nc, 32'h0);
        chk("R11 no-capture read err", {31'b0, err_nc}, 32'h1);

        // R12 counter write
        wr(4'h4, 32'd10);
        rd(4'h4); chk("R12 counter load", rv, 32'd10);

        // R3 dividers
        wr(4'h8, 32'h0); start = 1'b1;
        pulse(8);  rd(4'h4); chk("R3 div4", rv, 32'd8);
        wr(4'h8, 32'h1);
        pulse(15); rd(4'h4); chk("R3 div16 early", rv, 32'd8);
        pulse(1);  rd(4'h4); chk("R3 div16", rv, 32'd7);
        wr(4'h8, 32'h4);
        pulse(1023); rd(4'h4); chk("R3 div1024 early", rv, 32'd7);
        pulse(1);    rd(4'h4); chk("R3 div1024", rv, 32'd6);

        // R4 hold while stopped
        wr(4'h8, 32'h0);
        pulse(3); rd(4'h4); chk("R4 partial", rv, 32'd6);
        start = 1'b0;
        pulse(20); rd(4'h4); chk("R4 stopped", rv, 32'd6);
        start = 1'b1;
        pulse(1); rd(4'h4); chk("R4 phase kept", rv, 32'd5);

        // R8 restart on control write
        pulse(2);
        wr(4'h8, 32'h0);
        pulse(2); rd(4'h4); chk("R8 restarted", rv, 32'd5);
        pulse(2); rd(4'h4); chk("R8 full period", rv, 32'd4);

        // R5 / R7 underflow
        wr(4'h0, 32'd5);
        wr(4'h4, 32'd1);
        wr(4'h8, 32'h20);
        pulse(4); rd(4'h4); chk("R5 at zero", rv, 32'd0);
        chk("R7 irq before", {31'b0, irq}, 32'h0);
        pulse(4); rd(4'h4); chk("R5 reloaded", rv, 32'd5);
        rd(4'h8); chk("R5 flag", rv, 32'h120);
        chk("R7 irq set", {31'b0, irq}, 32'h1);

        // R6 flag write rules
        wr(4'h8, 32'h120);
        rd(4'h8); chk("R6 write 1 keeps", rv, 32'h120);
        wr(4'h8, 32'h100);
        rd(4'h8); chk("R6 enable off", rv, 32'h100);
        chk("R7 gated", {31'b0, irq}, 32'h0);
        wr(4'h8, 32'h000);
        rd(4'h8); chk("R6 clear", rv, 32'h0);
        wr(4'h8, 32'h120);
        rd(4'h8); chk("R6 never set", rv, 32'h020);
        chk("R7 irq low", {31'b0, irq}, 32'h0);

        // R11 misaligned access
        wr(4'h1, 32'hFFFF);
        chk("R11 misaligned err", {31'b0, err}, 32'h1);
        rd(4'h0); chk("R11 reload intact", rv, 32'd5);

        // R9 capture fields without capture option
        wr(4'h8, 32'h80);
        chk("R9 no-capture mode", {31'b0, err_nc}, 32'h1);
        wr(4'h8, 32'h200);
        chk("R9 no-capture flag", {31'b0, err_nc}, 32'h1);
        chk("R10 with capture ok", {31'b0, err}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule